// File: doc/BRIEF.md
# Parallel Key-Space Sweep Controller

This block searches one slice ("job") of a 56-bit key space by brute force. A 24-bit job number picks a run of 2^32 consecutive keys. Four cipher lanes each test one candidate key per clock, so the whole slice takes 2^30 cycles. At 100 MHz one instance tests 400 million keys per second. The cipher is not part of the block. It drives candidate keys out on `lane_key`, and the cipher lanes put their outputs back on `lane_res` after a fixed latency given by the parameter `LAT`. A delay line inside the block ties each returning result to the key that produced it.

Every job carries two targets. One is the real unknown. The other is a self-check target whose key is known to lie inside the job's slice. Matches on either target latch the matching key and set a sticky flag. The sweep runs to the end of the slice even after a real hit. When the slice is finished, the job is reported as faulty if the self-check key was never found. An over-temperature input stops key issue at once. A resume command later continues from the frozen counter.

The controller is a five-state machine:
- `S_IDLE`: waits after reset.
- `S_RUN`: issues keys.
- `S_HALT`: thermal stop.
- `S_DRAIN`: waits `LAT` cycles for in-flight results.
- `S_DONE`: slice finished.

Its transitions are:
- start: `S_IDLE`/`S_DONE` to `S_RUN`.
- overheat: `S_RUN` to `S_HALT`.
- resume: `S_HALT` to `S_RUN`.
- wrap: `S_RUN` to `S_DRAIN`, or straight to `S_DONE` when `LAT` is 0.
- drained: `S_DRAIN` to `S_DONE`.

Top module: `keysweep_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `job_error`, `real_hit` and `test_hit` are 0 and `progress` is 0.
- R2: In each issuing cycle with sweep counter value c, lane i (bits [i*KEY_W +: KEY_W] of `lane_key`) carries key {job, c, i}. The job number is in the top bits and the lane index in the low `LANE_BITS` bits. `progress` shows c, and c rises by one per issuing cycle, starting at 0.
- R3: A lane result equal to the real target sets `real_hit` and stores that lane's full key in `real_key`. Both hold until the next accepted start, and the sweep carries on.
- R4: A lane result equal to the self-check target sets `test_hit` and stores that key in `test_key`. Both hold until the next accepted start.
- R5: `busy` is high for exactly 2^CNT_W + LAT cycles of an uninterrupted sweep. Then `done` rises, with `job_error` = 1 exactly when `test_hit` is 0.
- R6: A result arriving on `lane_res` is attributed to the key driven on that lane `LAT` cycles earlier.
- R7: `overtemp` high in `S_RUN` issues no key that cycle. The next cycle has `busy` = 0 with `progress` unchanged.
- R8: In `S_HALT`, `cmd_resume` is ignored while `overtemp` is high. With `overtemp` low it returns to `S_RUN` at the frozen counter value, so no key is skipped or repeated.
- R9: `cfg_load` and `cmd_start` have no effect unless the block is in `S_IDLE` or `S_DONE`.
- R10: An accepted start from `S_DONE` clears `done`, both flags and both keys, and sets the counter to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Capture job number and both targets |
| cfg_job | input | JOB_W | Job number (top key bits) |
| cfg_real_tgt | input | BLK_W | Real target value |
| cfg_test_tgt | input | BLK_W | Self-check target value |
| cmd_start | input | 1 | Begin a new sweep |
| cmd_resume | input | 1 | Continue after a thermal stop |
| overtemp | input | 1 | Thermal fault, stops key issue |
| lane_key | output | LANES*KEY_W | Candidate key per lane |
| lane_res | input | LANES*BLK_W | Cipher output per lane, LAT cycles later |
| busy | output | 1 | Sweep in progress (`S_RUN` or `S_DRAIN`) |
| done | output | 1 | Sweep finished |
| job_error | output | 1 | Finished without finding the self-check key |
| real_hit | output | 1 | Real target found |
| test_hit | output | 1 | Self-check target found |
| real_key | output | KEY_W | Key that produced the real target |
| test_key | output | KEY_W | Key that produced the self-check target |
| progress | output | CNT_W | Current sweep counter |

## Verification
The bench uses a small configuration with 4-bit jobs, a 5-bit counter, four lanes and a two-stage toy cipher, and sweeps every one of the 16 jobs. In each job the real key is placed either inside the slice, which must produce a hit, or in the next slice, which must not. The self-check key is placed either inside the slice or outside it, which must produce a job fault. The choices include the first and last key of a slice, and a real and self-check key that share one cycle on different lanes. Thermal stops are placed on the first cycle, mid-sweep and on the final cycle, and a load-and-start is attempted mid-sweep. These show that halting loses and repeats no keys and that a running job cannot be overwritten.

// File: rtl/ks_pkg.sv
package ks_pkg;
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_RUN   = 3'd1,
        S_HALT  = 3'd2,
        S_DRAIN = 3'd3,
        S_DONE  = 3'd4
    } ks_state_e;
endpackage

// File: rtl/ks_keygen.sv
// Shared sweep counter and per-lane candidate key formation.
module ks_keygen #(
    parameter int JOB_W     = 24,
    parameter int CNT_W     = 30,
    parameter int LANE_BITS = 2,
    localparam int LANES    = 1 << LANE_BITS,
    localparam int KEY_W    = JOB_W + CNT_W + LANE_BITS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   step,
    input  logic [JOB_W-1:0]       job,
    output logic [CNT_W-1:0]       cnt,
    output logic                   last,
    output logic [LANES*KEY_W-1:0] lane_key
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt  = cnt_q;
    assign last = &cnt_q;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_key[i*KEY_W +: KEY_W] = {job, cnt_q, LANE_BITS'(i)};
    end
endmodule

// File: rtl/ks_key_delay.sv
// Delay line aligning issued base keys with pipelined lane results.
module ks_key_delay #(
    parameter int W     = 54,
    parameter int DEPTH = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_vld,
    input  logic [W-1:0] in_base,
    output logic         out_vld,
    output logic [W-1:0] out_base
);
    if (DEPTH == 0) begin : g_comb
        assign out_vld  = in_vld;
        assign out_base = in_base;
    end else begin : g_pipe
        logic [DEPTH-1:0] vld_q;
        logic [W-1:0]     base_q [DEPTH];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q <= '0;
            end else begin
                vld_q[0] <= in_vld;
                for (int s = 1; s < DEPTH; s++) begin
                    vld_q[s] <= vld_q[s-1];
                end
            end
        end

        always_ff @(posedge clk) begin
            base_q[0] <= in_base;
            for (int s = 1; s < DEPTH; s++) begin
                base_q[s] <= base_q[s-1];
            end
        end

        assign out_vld  = vld_q[DEPTH-1];
        assign out_base = base_q[DEPTH-1];
    end
endmodule

// File: rtl/ks_match.sv
// Per-lane target comparison with sticky hit flags and key capture.
module ks_match #(
    parameter int BASE_W    = 54,
    parameter int LANE_BITS = 2,
    parameter int BLK_W     = 64,
    localparam int LANES    = 1 << LANE_BITS,
    localparam int KEY_W    = BASE_W + LANE_BITS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   vld,
    input  logic [BASE_W-1:0]      base,
    input  logic [LANES*BLK_W-1:0] res,
    input  logic [BLK_W-1:0]       real_tgt,
    input  logic [BLK_W-1:0]       test_tgt,
    output logic                   real_hit,
    output logic                   test_hit,
    output logic [KEY_W-1:0]       real_key,
    output logic [KEY_W-1:0]       test_key
);
    logic [LANES-1:0]     r_eq, t_eq;
    logic [LANE_BITS-1:0] r_sel, t_sel;
    logic                 real_hit_q, test_hit_q;
    logic [KEY_W-1:0]     real_key_q, test_key_q;

    for (genvar i = 0; i < LANES; i++) begin : g_cmp
        assign r_eq[i] = vld && (res[i*BLK_W +: BLK_W] == real_tgt);
        assign t_eq[i] = vld && (res[i*BLK_W +: BLK_W] == test_tgt);
    end

    // Lowest lane index wins when several lanes match together.
    always_comb begin
        r_sel = '0;
        t_sel = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (r_eq[i]) r_sel = LANE_BITS'(i);
            if (t_eq[i]) t_sel = LANE_BITS'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            real_hit_q <= 1'b0;
            test_hit_q <= 1'b0;
            real_key_q <= '0;
            test_key_q <= '0;
        end else begin
            if (|r_eq && !real_hit_q) begin
                real_hit_q <= 1'b1;
                real_key_q <= {base, r_sel};
            end
            if (|t_eq && !test_hit_q) begin
                test_hit_q <= 1'b1;
                test_key_q <= {base, t_sel};
            end
        end
    end

    assign real_hit = real_hit_q;
    assign test_hit = test_hit_q;
    assign real_key = real_key_q;
    assign test_key = test_key_q;

    // R3: real hit and its key hold until the next start
    a_r3_real_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (real_hit_q && !clr) |=> (real_hit_q && $stable(real_key_q)));

    // R4: self-check hit and its key hold until the next start
    a_r4_test_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (test_hit_q && !clr) |=> (test_hit_q && $stable(test_key_q)));

    // R6: nothing is latched from a result slot that carries no issued key
    a_r6_no_stray_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (!vld && !real_hit_q && !clr) |=> !real_hit_q);
endmodule

// File: rtl/keysweep_ctrl.sv
// Sweep controller: state machine, configuration capture, lanes glue.
module keysweep_ctrl #(
    parameter int JOB_W     = 24,
    parameter int CNT_W     = 30,
    parameter int LANE_BITS = 2,
    parameter int BLK_W     = 64,
    parameter int LAT       = 0,
    localparam int LANES    = 1 << LANE_BITS,
    localparam int BASE_W   = JOB_W + CNT_W,
    localparam int KEY_W    = BASE_W + LANE_BITS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_load,
    input  logic [JOB_W-1:0]       cfg_job,
    input  logic [BLK_W-1:0]       cfg_real_tgt,
    input  logic [BLK_W-1:0]       cfg_test_tgt,
    input  logic                   cmd_start,
    input  logic                   cmd_resume,
    input  logic                   overtemp,
    output logic [LANES*KEY_W-1:0] lane_key,
    input  logic [LANES*BLK_W-1:0] lane_res,
    output logic                   busy,
    output logic                   done,
    output logic                   job_error,
    output logic                   real_hit,
    output logic                   test_hit,
    output logic [KEY_W-1:0]       real_key,
    output logic [KEY_W-1:0]       test_key,
    output logic [CNT_W-1:0]       progress
);
    import ks_pkg::*;

    localparam int DW = (LAT > 0) ? $clog2(LAT + 1) : 1;

    ks_state_e        state_q, state_d;
    logic [JOB_W-1:0] job_q;
    logic [BLK_W-1:0] real_tgt_q, test_tgt_q;
    logic [DW-1:0]    drn_q;
    logic             cfg_ok, start_ok, issue;
    logic [CNT_W-1:0] cnt;
    logic             last;
    logic             d_vld;
    logic [BASE_W-1:0] d_base;

    assign cfg_ok   = (state_q == S_IDLE) || (state_q == S_DONE);
    assign start_ok = cfg_ok && cmd_start;
    assign issue    = (state_q == S_RUN) && !overtemp;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            job_q      <= '0;
            real_tgt_q <= '0;
            test_tgt_q <= '0;
        end else if (cfg_ok && cfg_load) begin
            job_q      <= cfg_job;
            real_tgt_q <= cfg_real_tgt;
            test_tgt_q <= cfg_test_tgt;
        end
    end

    ks_keygen #(.JOB_W(JOB_W), .CNT_W(CNT_W), .LANE_BITS(LANE_BITS)) u_keygen (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (start_ok),
        .step     (issue),
        .job      (job_q),
        .cnt      (cnt),
        .last     (last),
        .lane_key (lane_key)
    );

    ks_key_delay #(.W(BASE_W), .DEPTH(LAT)) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (issue),
        .in_base  ({job_q, cnt}),
        .out_vld  (d_vld),
        .out_base (d_base)
    );

    ks_match #(.BASE_W(BASE_W), .LANE_BITS(LANE_BITS), .BLK_W(BLK_W)) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (start_ok),
        .vld      (d_vld),
        .base     (d_base),
        .res      (lane_res),
        .real_tgt (real_tgt_q),
        .test_tgt (test_tgt_q),
        .real_hit (real_hit),
        .test_hit (test_hit),
        .real_key (real_key),
        .test_key (test_key)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (cmd_start) state_d = S_RUN;
            S_RUN: begin
                if (overtemp)  state_d = S_HALT;
                else if (last) state_d = (LAT == 0) ? S_DONE : S_DRAIN;
            end
            S_HALT:  if (cmd_resume && !overtemp) state_d = S_RUN;
            S_DRAIN: if (drn_q == '0) state_d = S_DONE;
            S_DONE:  if (cmd_start) state_d = S_RUN;
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Drain countdown for results still inside the lanes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drn_q <= '0;
        end else if (issue && last) begin
            drn_q <= DW'(LAT - 1);
        end else if (state_q == S_DRAIN && drn_q != '0) begin
            drn_q <= drn_q - 1'b1;
        end
    end

    // Outputs
    always_comb begin
        busy      = (state_q == S_RUN) || (state_q == S_DRAIN);
        done      = (state_q == S_DONE);
        job_error = (state_q == S_DONE) && !test_hit;
        progress  = cnt;
    end

    // R7: thermal stop freezes the counter and leaves the run state
    a_r7_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && overtemp) |=> (state_q == S_HALT && $stable(cnt)));

    // R8: resume has no effect while still hot
    a_r8_hot_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HALT && overtemp) |=> (state_q == S_HALT && $stable(cnt)));

    // R9: configuration cannot change under a running job
    a_r9_job_locked: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(job_q) && $stable(real_tgt_q) && $stable(test_tgt_q)));

    // R5: completion is only reached from an active sweep
    a_r5_done_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));
endmodule

// File: tb/keysweep_ctrl_bench.sv
module keysweep_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int JW   = 4;
    localparam int CW   = 5;
    localparam int LB   = 2;
    localparam int BW   = 64;
    localparam int LAT  = 2;
    localparam int NL   = 1 << LB;
    localparam int KW   = JW + CW + LB;
    localparam int NCYC = 1 << CW;
    localparam int NJOB = 1 << JW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_load = 1'b0;
    logic [JW-1:0] cfg_job = '0;
    logic [BW-1:0] cfg_real_tgt = '0;
    logic [BW-1:0] cfg_test_tgt = '0;
    logic cmd_start = 1'b0;
    logic cmd_resume = 1'b0;
    logic overtemp = 1'b0;
    logic [NL*KW-1:0] lane_key;
    logic [NL*BW-1:0] lane_res;
    logic busy, done, job_error, real_hit, test_hit;
    logic [KW-1:0] real_key, test_key;
    logic [CW-1:0] progress;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    keysweep_ctrl #(.JOB_W(JW), .CNT_W(CW), .LANE_BITS(LB), .BLK_W(BW), .LAT(LAT)) u_keysweep_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_job(cfg_job),
        .cfg_real_tgt(cfg_real_tgt), .cfg_test_tgt(cfg_test_tgt),
        .cmd_start(cmd_start), .cmd_resume(cmd_resume), .overtemp(overtemp),
        .lane_key(lane_key), .lane_res(lane_res), .busy(busy), .done(done),
        .job_error(job_error), .real_hit(real_hit), .test_hit(test_hit),
        .real_key(real_key), .test_key(test_key), .progress(progress)
    );

    // Toy cipher: injective odd-constant multiply, two pipeline stages.
    function automatic logic [BW-1:0] mix(input logic [KW-1:0] k);
        logic [63:0] x;
        x = 64'(k);
        return (x * 64'h9E37_79B9_7F4A_7C15) ^ 64'h5A5A_0F0F_3C3C_C3C3;
    endfunction

    logic [NL*BW-1:0] p1 = '0;
    logic [NL*BW-1:0] p2 = '0;
    always_ff @(posedge clk) begin
        for (int l = 0; l < NL; l++) p1[l*BW +: BW] <= mix(lane_key[l*KW +: KW]);
        p2 <= p1;
    end
    assign lane_res = p2;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_job(input int job, input logic [KW-1:0] kr, input logic [KW-1:0] kt,
                           input int halt_at, input int load_at);
        int  bc;
        int  guard;
        int  perr;
        bit  halted;
        bit  exp_r, exp_t;
        exp_r = (kr[KW-1 -: JW] == JW'(job));
        exp_t = (kt[KW-1 -: JW] == JW'(job));
        @(negedge clk);
        cfg_load = 1'b1; cfg_job = JW'(job);
        cfg_real_tgt = mix(kr); cfg_test_tgt = mix(kt);
        @(negedge clk);
        cfg_load = 1'b0; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        check("R10 start clears done/flags", {busy, done, real_hit, test_hit, 60'(real_key)}, {4'b1000, 60'd0});
        bc = 0; guard = 0; perr = 0; halted = 0;
        while (!done && guard < 2000) begin
            guard++;
            if (busy) begin
                if (bc < NCYC) begin
                    if (progress !== CW'(bc)) perr++;
                    for (int l = 0; l < NL; l++)
                        if (lane_key[l*KW +: KW] !== {JW'(job), CW'(bc), LB'(l)}) perr++;
                end
                if (bc == load_at) begin
                    cfg_load = 1'b1; cmd_start = 1'b1; cfg_job = JW'(job + 1);
                    cfg_real_tgt = mix(kt); cfg_test_tgt = mix(kr);
                end
                if (bc == halt_at && !halted) begin
                    halted = 1;
                    overtemp = 1'b1;
                    @(negedge clk);
                    check("R7 busy drops on overtemp", 64'(busy), 64'd0);
                    check("R7 progress frozen", 64'(progress), 64'(bc));
                    cmd_resume = 1'b1;
                    @(negedge clk);
                    cmd_resume = 1'b0;
                    check("R8 hot resume ignored", {busy, 59'(progress)}, {1'b0, 59'(bc)});
                    repeat (3) @(negedge clk);
                    overtemp = 1'b0;
                    cmd_resume = 1'b1;
                    @(negedge clk);
                    cmd_resume = 1'b0;
                    check("R8 resume at frozen count", {busy, 59'(progress)}, {1'b1, 59'(bc)});
                    continue;
                end
                bc++;
            end
            @(negedge clk);
            cfg_load = 1'b0; cmd_start = 1'b0;
        end
        check("R2 key/progress sequence errors", 64'(perr), 64'd0);
        check("R5 done reached", 64'(done), 64'd1);
        check("R5 busy cycle count", 64'(bc), 64'(NCYC + LAT));
        check("R3 real_hit", 64'(real_hit), 64'(exp_r));
        if (exp_r) check("R3 R6 real_key", 64'(real_key), 64'(kr));
        check("R4 test_hit", 64'(test_hit), 64'(exp_t));
        if (exp_t) check("R4 R6 test_key", 64'(test_key), 64'(kt));
        check("R5 job_error", 64'(job_error), 64'(!exp_t));
        if (load_at >= 0) check("R9 load during run ignored", {real_hit, test_hit}, {exp_r, exp_t});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset state", {busy, done, job_error, real_hit, test_hit, 59'(progress)}, 64'd0);
        // R9: start with nothing loaded is accepted from idle; here check resume in idle does nothing
        cmd_resume = 1'b1;
        @(negedge clk);
        cmd_resume = 1'b0;
        check("R9 resume in idle ignored", {busy, done}, 2'b00);
        for (int j = 0; j < NJOB; j++) begin
            int cr, lr, ct, lt, rj, tj, h, ld;
            cr = (j * 7 + 3) % NCYC;  lr = j % NL;
            ct = (j * 11 + 5) % NCYC; lt = (j + 1) % NL;
            rj = (j % 2 == 1) ? (j + 1) % NJOB : j;
            tj = (j % 4 == 3) ? (j + 2) % NJOB : j;
            if (j == 0)  begin ct = 0; lt = 0; end
            if (j == 15) begin ct = NCYC - 1; lt = NL - 1; tj = j; end
            if (j == 2)  begin ct = cr; lt = (lr + 1) % NL; end
            h  = (j == 5) ? 10 : (j == 9) ? 0 : (j == 12) ? NCYC - 1 : -1;
            ld = (j == 6) ? 4 : -1;
            run_job(j, {JW'(rj), CW'(cr), LB'(lr)}, {JW'(tj), CW'(ct), LB'(lt)}, h, ld);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule